// File: doc/BRIEF.md
# Chip-Select Region Decoder

This block maps a 32-bit system address onto one of eight external chip-select regions. Each region is described by a map word that holds a 6-bit base, a 4-bit size mask and an enable bit, and by a type word that marks the attached device as memory-like or NAND-like. When an address falls inside an enabled region, the decoder drives a one-hot chip select and the offset of the address within that region. It also reports where the access should be steered: to plain memory, to the direct NAND access window, or to the prefetch FIFO window.

All configuration is held in registers inside the block and is loaded through a single write port. The decode itself is purely combinational from the address and the stored configuration, so a lookup completes in the same cycle. When regions overlap, the lowest-numbered region wins and a separate flag reports the overlap. A further flag reports any enabled region that holds a mask encoding outside the legal set.

Top module: `cs_region_decoder`

## Requirements
- R1: Map word layout: base in bits 5:0, enable in bit 6, mask in bits 11:8. An enabled region matches an address when address bits 31:30 are zero, address bits 29:28 equal base bits 5:4, and address bits 27:24 equal base bits 3:0 in every position where the mask bit is 1.
- R2: Region size is (0x0FFFFFFF & ~(mask << 24)) + 1, so masks 0xF, 0xE, 0xC and 0x8 give 16, 32, 64 and 128 MB. The offset output is the address ANDed with (size - 1), and it is zero when nothing matches.
- R3: A region whose enable bit is clear never drives its chip select, whatever its base and mask hold.
- R4: When several enabled regions match, only the lowest-numbered one is selected, and the overlap output is 1. With zero or one match the overlap output is 0.
- R5: The chip-select output has at most one bit set; the hit output is 1 exactly when a bit is set.
- R6: Route output encoding: 0 = no hit, 1 = memory, 2 = direct NAND, 3 = prefetch FIFO. A hit region whose type field (type word bits 11:10) is not 2 routes to memory. A type-2 region routes to the prefetch FIFO when the prefetch enable (prefetch word bit 7) is 1 and the prefetch chip-select field (prefetch word bits 26:24) equals its index, and to direct NAND otherwise.
- R7: The configuration error output is 1 when any enabled region holds a mask other than 0x8, 0xC, 0xE or 0xF; mask 0x0 is also accepted when the ALLOW_FULL_MASK parameter is 1 (default 0). Disabled regions never raise it.
- R8: After reset, region 0 is enabled with base 0 and mask 0xF, regions 1 to 7 are disabled with base 0 and mask 0xF, all type fields are 0, and the prefetch enable and chip-select field are 0.
- R9: Write selector encoding: 0 = map word of region cfg_idx_i, 1 = type word of region cfg_idx_i, 2 = prefetch word, 3 = no effect. A write takes effect from the next clock edge; bits outside the fields named in R1 and R6 are discarded, and without a write the configuration holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Which word to write (R9 encoding) |
| cfg_idx_i | input | 3 | Region index for map and type writes |
| cfg_wdata_i | input | 32 | Configuration write data |
| addr_i | input | 32 | System address to decode |
| cs_sel_o | output | 8 | One-hot chip select of the winning region |
| hit_o | output | 1 | Address falls in an enabled region |
| offset_o | output | 32 | Offset of the address within the winning region |
| route_o | output | 2 | Target window (R6 encoding) |
| overlap_o | output | 1 | More than one enabled region matches |
| cfg_err_o | output | 1 | An enabled region holds an illegal mask |

## Verification
A configuration write and a decode can land in the same cycle: an address that hits a region is presented while that region's map word, or the prefetch word that retargets it, is being rewritten. The bench provokes this both in directed steps and in a long stretch of random writes mixed with random addresses, and its reference model commits each write only at the clock edge that captures it. Every cycle the decode outputs must therefore reflect the old configuration until that edge and the new one after it.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

   // route codes on route_o
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_MEM  = 2'd1,
      ROUTE_NAND = 2'd2,
      ROUTE_FIFO = 2'd3
   } route_e;

   // write selector codes on cfg_sel_i
   localparam logic [1:0] CFG_MAP  = 2'd0;
   localparam logic [1:0] CFG_TYPE = 2'd1;
   localparam logic [1:0] CFG_PF   = 2'd2;

   // field positions inside the configuration words
   localparam int MAP_VALID_BIT = 6;
   localparam int MAP_MASK_LSB  = 8;
   localparam int TYPE_LSB      = 10;
   localparam int TYPE_W        = 2;
   localparam int PF_EN_BIT     = 7;
   localparam int PF_CS_LSB     = 24;
   localparam int PF_CS_W       = 3;

   localparam logic [TYPE_W-1:0] DEV_NAND = 2'd2;

endpackage

// File: rtl/csdec_cfg_regs.sv
module csdec_cfg_regs
   import csdec_pkg::*;
#(
   parameter int NUM_CS = 8,
   parameter int BASE_W = 6,
   parameter int MASK_W = 4,
   parameter int CS_W   = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_we,
   input  logic [1:0]                       cfg_sel,
   input  logic [CS_W-1:0]                  cfg_idx,
   input  logic [31:0]                      cfg_wdata,
   output logic [NUM_CS-1:0][BASE_W-1:0]    base_o,
   output logic [NUM_CS-1:0][MASK_W-1:0]    mask_o,
   output logic [NUM_CS-1:0]                valid_o,
   output logic [NUM_CS-1:0][TYPE_W-1:0]    type_o,
   output logic                             pf_en_o,
   output logic [PF_CS_W-1:0]               pf_cs_o
);

   logic unused_wdata;
   assign unused_wdata = ^{cfg_wdata[31:27], cfg_wdata[23:12], cfg_wdata[7]};

   for (genvar g = 0; g < NUM_CS; g++) begin : g_region
      logic hit_idx;
      assign hit_idx = cfg_we && (cfg_idx == CS_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_o[g]  <= '0;
            mask_o[g]  <= '1;
            valid_o[g] <= (g == 0);
            type_o[g]  <= '0;
         end else if (hit_idx) begin
            if (cfg_sel == CFG_MAP) begin
               base_o[g]  <= cfg_wdata[BASE_W-1:0];
               mask_o[g]  <= cfg_wdata[MAP_MASK_LSB +: MASK_W];
               valid_o[g] <= cfg_wdata[MAP_VALID_BIT];
            end else if (cfg_sel == CFG_TYPE) begin
               type_o[g]  <= cfg_wdata[TYPE_LSB +: TYPE_W];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_en_o <= 1'b0;
         pf_cs_o <= '0;
      end else if (cfg_we && cfg_sel == CFG_PF) begin
         pf_en_o <= cfg_wdata[PF_EN_BIT];
         pf_cs_o <= cfg_wdata[PF_CS_LSB +: PF_CS_W];
      end
   end

   // R9
   map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(base_o) && $stable(mask_o) && $stable(valid_o)
                   && $stable(type_o) && $stable(pf_en_o) && $stable(pf_cs_o)));

endmodule

// File: rtl/csdec_region_match.sv
module csdec_region_match #(
   parameter int ADDR_W          = 32,
   parameter int BASE_W          = 6,
   parameter int MASK_W          = 4,
   parameter int SHIFT           = 24,
   parameter bit ALLOW_FULL_MASK = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BASE_W-1:0] base,
   input  logic [MASK_W-1:0] mask,
   input  logic              valid,
   output logic              match,
   output logic [ADDR_W-1:0] span,
   output logic              mask_ok
);

   localparam int HI  = SHIFT + MASK_W;
   localparam int BHI = SHIFT + BASE_W;

   logic upper_ok, mid_ok, low_ok;
   logic unused_low;
   assign unused_low = ^addr[SHIFT-1:0];

   if (BHI < ADDR_W) begin : g_upper
      assign upper_ok = (addr[ADDR_W-1:BHI] == '0);
   end else begin : g_no_upper
      assign upper_ok = 1'b1;
   end

   assign mid_ok = (addr[BHI-1:HI] == base[BASE_W-1:MASK_W]);
   assign low_ok = (((addr[HI-1:SHIFT] ^ base[MASK_W-1:0]) & mask) == '0);
   assign match  = valid && upper_ok && mid_ok && low_ok;

   always_comb begin
      span            = '0;
      span[HI-1:0]    = '1;
      span[HI-1:SHIFT] = ~mask;
   end

   // legal masks are a run of ones from the top bit down
   logic [MASK_W-1:0] inv;
   logic              thermo;
   assign inv    = ~mask;
   assign thermo = ((inv & (inv + 1'b1)) == '0);
   assign mask_ok = (mask == '0) ? ALLOW_FULL_MASK : thermo;

endmodule

// File: rtl/csdec_prio_select.sv
module csdec_prio_select
   import csdec_pkg::*;
#(
   parameter int NUM_CS = 8,
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic [NUM_CS-1:0]               match_vec,
   input  logic [NUM_CS-1:0][ADDR_W-1:0]   span,
   input  logic [NUM_CS-1:0][TYPE_W-1:0]   dev_type,
   input  logic                            pf_en,
   input  logic [PF_CS_W-1:0]              pf_cs,
   output logic [NUM_CS-1:0]               cs_sel,
   output logic                            hit,
   output logic                            overlap,
   output logic [ADDR_W-1:0]               offset,
   output route_e                          route
);

   assign hit     = |match_vec;
   assign overlap = ((match_vec & (match_vec - NUM_CS'(1))) != '0);
   assign cs_sel  = match_vec & (~match_vec + NUM_CS'(1));

   always_comb begin
      offset = '0;
      route  = ROUTE_NONE;
      for (int i = 0; i < NUM_CS; i++) begin
         if (cs_sel[i]) begin
            offset = offset | (addr & span[i]);
            if (dev_type[i] == DEV_NAND) begin
               route = (pf_en && pf_cs == PF_CS_W'(i)) ? ROUTE_FIFO : ROUTE_NAND;
            end else begin
               route = ROUTE_MEM;
            end
         end
      end
   end

endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
   import csdec_pkg::*;
#(
   parameter int NUM_CS          = 8,
   parameter int ADDR_W          = 32,
   parameter int BASE_W          = 6,
   parameter int MASK_W          = 4,
   parameter int SHIFT           = 24,
   parameter bit ALLOW_FULL_MASK = 1'b0,
   localparam int CS_W           = $clog2(NUM_CS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we_i,
   input  logic [1:0]        cfg_sel_i,
   input  logic [CS_W-1:0]   cfg_idx_i,
   input  logic [31:0]       cfg_wdata_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NUM_CS-1:0] cs_sel_o,
   output logic              hit_o,
   output logic [ADDR_W-1:0] offset_o,
   output logic [1:0]        route_o,
   output logic              overlap_o,
   output logic              cfg_err_o
);

   if (NUM_CS < 2 || NUM_CS > (1 << PF_CS_W)) begin : g_bad_num_cs
      $error("NUM_CS must lie between 2 and 8");
   end
   if (BASE_W > MAP_VALID_BIT || MASK_W > TYPE_LSB - MAP_MASK_LSB + 2) begin : g_bad_fields
      $error("base or mask field does not fit the map word");
   end
   if (MASK_W >= BASE_W || MASK_W < 1) begin : g_bad_mask_w
      $error("MASK_W must be at least 1 and below BASE_W");
   end
   if (SHIFT < 1 || SHIFT + BASE_W > ADDR_W) begin : g_bad_shift
      $error("SHIFT places the base outside the address");
   end

   logic [NUM_CS-1:0][BASE_W-1:0] base_q;
   logic [NUM_CS-1:0][MASK_W-1:0] mask_q;
   logic [NUM_CS-1:0]             valid_q;
   logic [NUM_CS-1:0][TYPE_W-1:0] type_q;
   logic                          pf_en_q;
   logic [PF_CS_W-1:0]            pf_cs_q;

   csdec_cfg_regs #(
      .NUM_CS (NUM_CS),
      .BASE_W (BASE_W),
      .MASK_W (MASK_W),
      .CS_W   (CS_W)
   ) cfg_regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we_i),
      .cfg_sel   (cfg_sel_i),
      .cfg_idx   (cfg_idx_i),
      .cfg_wdata (cfg_wdata_i),
      .base_o    (base_q),
      .mask_o    (mask_q),
      .valid_o   (valid_q),
      .type_o    (type_q),
      .pf_en_o   (pf_en_q),
      .pf_cs_o   (pf_cs_q)
   );

   logic [NUM_CS-1:0]             match_vec;
   logic [NUM_CS-1:0]             mask_ok_vec;
   logic [NUM_CS-1:0][ADDR_W-1:0] span_vec;

   for (genvar g = 0; g < NUM_CS; g++) begin : g_match
      csdec_region_match #(
         .ADDR_W          (ADDR_W),
         .BASE_W          (BASE_W),
         .MASK_W          (MASK_W),
         .SHIFT           (SHIFT),
         .ALLOW_FULL_MASK (ALLOW_FULL_MASK)
      ) match_i (
         .addr    (addr_i),
         .base    (base_q[g]),
         .mask    (mask_q[g]),
         .valid   (valid_q[g]),
         .match   (match_vec[g]),
         .span    (span_vec[g]),
         .mask_ok (mask_ok_vec[g])
      );
   end

   route_e route_w;

   csdec_prio_select #(
      .NUM_CS (NUM_CS),
      .ADDR_W (ADDR_W)
   ) prio_i (
      .addr      (addr_i),
      .match_vec (match_vec),
      .span      (span_vec),
      .dev_type  (type_q),
      .pf_en     (pf_en_q),
      .pf_cs     (pf_cs_q),
      .cs_sel    (cs_sel_o),
      .hit       (hit_o),
      .overlap   (overlap_o),
      .offset    (offset_o),
      .route     (route_w)
   );

   assign route_o   = route_w;
   assign cfg_err_o = |(valid_q & ~mask_ok_vec);

   // R5
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_sel_o));

   // R5
   hit_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o == (cs_sel_o != '0));

   // R3
   valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_sel_o & ~valid_q) == '0);

   // R4
   overlap_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overlap_o |-> hit_o);

   // R6
   route_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (route_o != ROUTE_NONE));

   // R2
   offset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> (offset_o == '0));

endmodule

// File: tb/cs_region_decoder_tb.sv
`timescale 1ns/1ps
module cs_region_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [2:0]  cfg_idx = 3'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic [31:0] addr = 32'd0;
   logic [7:0]  cs_sel;
   logic        hit;
   logic [31:0] offset;
   logic [1:0]  route;
   logic        overlap;
   logic        cfg_err;

   always #2.5 clk = ~clk;

   cs_region_decoder dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we_i    (cfg_we),
      .cfg_sel_i   (cfg_sel),
      .cfg_idx_i   (cfg_idx),
      .cfg_wdata_i (cfg_wdata),
      .addr_i      (addr),
      .cs_sel_o    (cs_sel),
      .hit_o       (hit),
      .offset_o    (offset),
      .route_o     (route),
      .overlap_o   (overlap),
      .cfg_err_o   (cfg_err)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference configuration state
   logic [5:0] m_base [8];
   logic [3:0] m_mask [8];
   logic       m_valid[8];
   logic [1:0] m_type [8];
   logic       m_pfen;
   logic [2:0] m_pfcs;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h addr=%h t=%0t", tag, act, exp, addr, $time);
      end
   endtask

   // model commits a write at the edge that captures it
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin
            m_base[i] = 6'd0; m_mask[i] = 4'hF; m_valid[i] = (i == 0); m_type[i] = 2'd0;
         end
         m_pfen = 1'b0; m_pfcs = 3'd0;
      end else if (cfg_we) begin
         case (cfg_sel)
            2'd0: begin
               m_base[cfg_idx]  = cfg_wdata[5:0];
               m_valid[cfg_idx] = cfg_wdata[6];
               m_mask[cfg_idx]  = cfg_wdata[11:8];
            end
            2'd1: m_type[cfg_idx] = cfg_wdata[11:10];
            2'd2: begin m_pfen = cfg_wdata[7]; m_pfcs = cfg_wdata[26:24]; end
            default: ;
         endcase
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [31:0] span, start, e_off;
         logic [7:0]  e_cs;
         int          first, cnt;
         logic [1:0]  e_route;
         logic        e_err;
         e_cs = 8'd0; first = -1; cnt = 0; e_off = 32'd0; e_route = 2'd0; e_err = 1'b0;
         for (int i = 0; i < 8; i++) begin
            span  = 32'h0FFFFFFF & ~({28'd0, m_mask[i]} << 24);
            start = {26'd0, m_base[i]} << 24;
            if (m_valid[i] && ((addr & ~span) == (start & ~span))) begin
               cnt++;
               if (first < 0) begin
                  first = i;
                  e_cs[i] = 1'b1;
                  e_off = addr & span;
                  if (m_type[i] != 2'd2) e_route = 2'd1;
                  else if (m_pfen && m_pfcs == i[2:0]) e_route = 2'd3;
                  else e_route = 2'd2;
               end
            end
            if (m_valid[i] && !(m_mask[i] inside {4'h8, 4'hC, 4'hE, 4'hF})) e_err = 1'b1;
         end
         check("R1 R3 R4 chip select", {24'd0, cs_sel}, {24'd0, e_cs});
         check("R5 hit", {31'd0, hit}, {31'd0, cnt > 0});
         check("R2 offset", offset, e_off);
         check("R6 route", {30'd0, route}, {30'd0, e_route});
         check("R4 overlap", {31'd0, overlap}, {31'd0, cnt > 1});
         check("R7 config error", {31'd0, cfg_err}, {31'd0, e_err});
      end
   end

   task automatic step(input logic [31:0] a);
      @(posedge clk); #1;
      cfg_we = 1'b0;
      addr = a;
   endtask

   task automatic wr(input logic [1:0] s, input logic [2:0] idx, input logic [31:0] d,
                     input logic [31:0] a);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_sel = s; cfg_idx = idx; cfg_wdata = d; addr = a;
   endtask

   function automatic logic [31:0] mapw(input logic [5:0] b, input logic [3:0] m, input logic v);
      return {20'd0, m, 1'b0, v, b};
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      addr = 32'h0012_3456;
      @(negedge clk);
      // R8 reset: region 0 live with 16 MB, others silent
      check("R8 reset cs", {24'd0, cs_sel}, 32'h1);
      check("R8 reset offset", offset, 32'h0012_3456);
      check("R8 reset route", {30'd0, route}, 32'd1);
      step(32'h00FF_FFFF);
      step(32'h0100_0000);          // R8 region 1 disabled
      step(32'h4000_0000);          // R1 bit 30 set
      // R1 R2 region 1: base 4, 64 MB
      wr(2'd0, 3'd1, mapw(6'h04, 4'hC, 1'b1), 32'h0400_0000);
      step(32'h0400_0000);
      step(32'h07FF_FFFF);
      step(32'h0800_0000);
      @(negedge clk);
      check("R2 above region", {31'd0, hit}, 32'd0);
      // R1 base bits inside the size are ignored
      wr(2'd0, 3'd1, mapw(6'h05, 4'hC, 1'b1), 32'h0600_0010);
      step(32'h0600_0010);
      @(negedge clk);
      check("R1 unaligned base", offset, 32'h0200_0010);
      // R6 NAND regions 2 and 3, overlapping; R4 lowest wins
      wr(2'd0, 3'd2, mapw(6'h10, 4'h8, 1'b1), 32'h1200_0000);
      wr(2'd1, 3'd2, 32'hFFFF_FBFF & 32'h0000_0800, 32'h1200_0000);
      wr(2'd0, 3'd3, mapw(6'h12, 4'hF, 1'b1), 32'h1200_0000);
      wr(2'd1, 3'd3, 32'h0000_0800, 32'h1234_5678);
      step(32'h1234_5678);
      @(negedge clk);
      check("R4 overlap winner", {24'd0, cs_sel}, 32'h4);
      check("R4 overlap flag", {31'd0, overlap}, 32'd1);
      check("R6 nand direct", {30'd0, route}, 32'd2);
      // R6 prefetch targets region 2, then region 3, while hitting
      wr(2'd2, 3'd0, 32'h0200_0080, 32'h1234_5678);
      step(32'h1234_5678);
      @(negedge clk);
      check("R6 fifo route", {30'd0, route}, 32'd3);
      wr(2'd2, 3'd0, 32'h0300_0080, 32'h1300_0000);
      step(32'h1300_0000);
      step(32'h1700_0000);
      wr(2'd2, 3'd0, 32'h0200_0000, 32'h1100_0000);  // enable clear
      step(32'h1100_0000);
      // R9 selector 3 writes nothing
      wr(2'd3, 3'd2, 32'hFFFF_FFFF, 32'h1100_0000);
      step(32'h1100_0000);
      @(negedge clk);
      check("R9 ignored write", {30'd0, route}, 32'd2);
      // R7 illegal and full masks, then disabled
      wr(2'd0, 3'd4, mapw(6'h20, 4'h5, 1'b1), 32'h2000_0000);
      step(32'h2000_0000);
      @(negedge clk);
      check("R7 illegal mask", {31'd0, cfg_err}, 32'd1);
      wr(2'd0, 3'd4, mapw(6'h20, 4'h0, 1'b1), 32'h2F00_0000);
      step(32'h2F00_0000);
      wr(2'd0, 3'd4, mapw(6'h20, 4'h5, 1'b0), 32'h2000_0000);
      step(32'h2000_0000);
      @(negedge clk);
      check("R7 disabled region", {31'd0, cfg_err}, 32'd0);
      // R3 disable region 0 while hitting it
      wr(2'd0, 3'd0, mapw(6'h00, 4'hF, 1'b0), 32'h0000_0040);
      step(32'h0000_0040);
      @(negedge clk);
      check("R3 disabled region", {31'd0, hit}, 32'd0);
      // random mix of writes and addresses
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] a;
         a = $urandom;
         if (n % 4 != 0) a = a & 32'h3FFF_FFFF;
         if (n % 5 == 0) begin
            logic [31:0] d;
            d = $urandom;
            if (n % 3 == 0) d[11:8] = 4'hF - 4'(($urandom % 4) == 0 ? 0 : (1 << ($urandom % 3)) - 1);
            wr(2'($urandom), 3'($urandom), d, a);
         end else begin
            step(a);
         end
      end
      step(32'd0);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule